// File: doc/BRIEF.md
# Three-Channel Match and Wrap Timer

This is a register-mapped timer block with three independent counters of `CNT_W` bits. Each counter advances once per bus clock while it is running. A per-channel direction bit makes it count up or down. When a counter passes its end value it reloads from its own reload register. Each counter also raises an event when its value equals either of two compare registers.

Event flags for all channels sit together in one shared status word, and one shared mask word gates them. Each channel drives its own interrupt line. That line is on when the channel's interrupt enable is set and at least one of its unmasked status flags is set.

Software uses the block through a single-cycle bus with word addressing:
- A write takes effect at the clock edge on which it is presented.
- A read returns its data on `bus_rdata` after that edge. The value is held until the next read.

A periodic tick comes from one of two set-ups:
- Count up from a reload value near the top of the range, using the wrap event.
- Count down from a reload value, using the wrap event or a compare value of zero.

Top module: `tri_event_timer`

## Requirements
- R1: After a synchronous reset, every counter, reload, compare, control and status bit reads as 0, the mask word reads 0x1FF (all sources masked), and `tmr_irq` is 0.
- R2: Word index 4i+0/1/2/3 selects channel i's counter, reload, compare A and compare B (i = 0..2). Index 12 is control, 13 is status and 14 is mask. Index 15 reads 0. The word at `bus_addr` appears on `bus_rdata` one clock after a cycle with `bus_rd` high, and is held otherwise.
- R3: Writing a counter word sets that counter to the written value at the same edge. This overrides any step the counter would have taken.
- R4: With control bit 9+i set and control bit 3i set, channel i steps +1 per clock. From all ones it reloads the reload value and raises its wrap flag, status bit 3i+2.
- R5: With control bit 9+i clear and control bit 3i set, channel i steps −1 per clock. From zero it reloads the reload value and raises its wrap flag. So a reload value L gives a wrap every L+1 clocks.
- R6: While control bit 3i is clear, channel i's counter holds its value. Setting the bit again resumes from that value.
- R7: While channel i runs and is not being written, a counter equal to compare A sets status bit 3i, and a counter equal to compare B sets status bit 3i+1. The flag is visible from the next edge.
- R8: Writing status clears each bit written as 1. A flag raised in the same cycle as its clear stays set.
- R9: `tmr_irq[i]` is the registered OR of channel i's status bits whose mask bit is 0, gated by control bit 3i+2. It follows the status word by one clock.
- R10: Control bit 3i+1 (clock-source select) is stored and read back but does not change counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tmr_irq | output | 3 | Interrupt line per channel |

## Verification
Counting is driven with directed set-ups that isolate one behaviour each:
- An up count started just below all ones separates a reload from a plain roll-over to zero.
- A down count through zero with zero compare values shows the wrap flag and both compare flags raised on the same clock.
- An up count crossing two nearby compare values shows that each flag belongs to its own register.
- A compare hit timed onto the clock of a status clear separates "event wins" from "clear wins".

After these, random mixes of writes run all three channels against a cycle model in the bench. The writes favour values near zero and near all ones, and use random directions, enables and masks. This model comparison catches faults that appear only when channels interact or when a counter write lands on a wrap edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // position of a register inside one channel's four-word block
  typedef enum logic [1:0] {
    SLOT_COUNT  = 2'd0,
    SLOT_RELOAD = 2'd1,
    SLOT_CMP_A  = 2'd2,
    SLOT_CMP_B  = 2'd3
  } slot_e;

  // per-channel event bundle; bit 0 is compare A, bit 2 is the wrap
  typedef struct packed {
    logic wrap;
    logic hit_b;
    logic hit_a;
  } tmr_evt_t;

  localparam int EVT_PER_CH = 3;

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             dir_up,
  input  logic             cnt_we,
  input  logic             rld_we,
  input  logic             cmpa_we,
  input  logic             cmpb_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rld_q,
  output logic [CNT_W-1:0] cmpa_q,
  output logic [CNT_W-1:0] cmpb_q,
  output tmr_evt_t         evt
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic stepping;
  logic at_end;

  assign stepping = run && !cnt_we;
  assign at_end   = dir_up ? (cnt_q == TOP) : (cnt_q == '0);

  always_comb begin
    evt.hit_a = stepping && (cnt_q == cmpa_q);
    evt.hit_b = stepping && (cnt_q == cmpb_q);
    evt.wrap  = stepping && at_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else begin
      if (rld_we)  rld_q  <= wdata;
      if (cmpa_we) cmpa_q <= wdata;
      if (cmpb_we) cmpb_q <= wdata;
      if (cnt_we)
        cnt_q <= wdata;
      else if (run) begin
        if (at_end)      cnt_q <= rld_q;
        else if (dir_up) cnt_q <= cnt_q + 1'b1;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R3
  cnt_write_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> cnt_q == $past(wdata));

  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we) |=> $stable(cnt_q));

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && dir_up && !cnt_we && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R5
  down_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !dir_up && !cnt_we && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
  import tmr_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [EVT_PER_CH*N_CH-1:0] evt_in,
  input  logic                       clr_we,
  input  logic                       mask_we,
  input  logic [EVT_PER_CH*N_CH-1:0] wbits,
  input  logic [N_CH-1:0]            irq_en,
  output logic [EVT_PER_CH*N_CH-1:0] st_q,
  output logic [EVT_PER_CH*N_CH-1:0] mask_q,
  output logic [N_CH-1:0]            irq_q
);

  localparam int EV_W = EVT_PER_CH * N_CH;

  logic [EV_W-1:0] live;
  assign live = st_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      mask_q <= '1;
    end else begin
      st_q <= (st_q & ~(clr_we ? wbits : '0)) | evt_in;
      if (mask_we) mask_q <= wbits;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq_q[c] <= 1'b0;
      else     irq_q[c] <= irq_en[c] && (|live[EVT_PER_CH*c +: EVT_PER_CH]);
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (mask_q == '1 && st_q == '0 && irq_q == '0));

  // R8
  event_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_in != '0) |=> ((st_q & $past(evt_in)) == $past(evt_in)));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_q & ~$past(irq_en)) == '0));

endmodule

// File: rtl/tri_event_timer.sv
module tri_event_timer
  import tmr_pkg::*;
#(
  parameter int N_CH   = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [N_CH-1:0]   tmr_irq
);

  localparam int EV_W   = EVT_PER_CH * N_CH;
  localparam int CTRL_W = 4 * N_CH;
  localparam int BLK_W  = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] CTRL_IDX = ADDR_W'(4 * N_CH);
  localparam logic [ADDR_W-1:0] STAT_IDX = ADDR_W'(4 * N_CH + 1);
  localparam logic [ADDR_W-1:0] MASK_IDX = ADDR_W'(4 * N_CH + 2);

  initial begin
    if (4 * N_CH + 3 > (1 << ADDR_W)) $error("address space too small");
    if (CNT_W < CTRL_W) $error("data word narrower than control word");
  end

  logic [CTRL_W-1:0] ctrl_q;
  logic [EV_W-1:0]   evt_all;
  logic [EV_W-1:0]   st_q, mask_q;
  logic [N_CH-1:0]   ie;
  logic [CNT_W-1:0]  cnt_a  [N_CH];
  logic [CNT_W-1:0]  rld_a  [N_CH];
  logic [CNT_W-1:0]  cmpa_a [N_CH];
  logic [CNT_W-1:0]  cmpb_a [N_CH];
  logic [CNT_W-1:0]  rd_mux;

  always_ff @(posedge clk) begin
    if (rst)                              ctrl_q <= '0;
    else if (bus_wr && bus_addr == CTRL_IDX) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic     blk_hit;
    tmr_evt_t ev;
    assign blk_hit = bus_wr && (bus_addr[ADDR_W-1:2] == BLK_W'(c));
    assign ie[c]   = ctrl_q[3*c+2];

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .run     (ctrl_q[3*c]),
      .dir_up  (ctrl_q[3*N_CH+c]),
      .cnt_we  (blk_hit && bus_addr[1:0] == SLOT_COUNT),
      .rld_we  (blk_hit && bus_addr[1:0] == SLOT_RELOAD),
      .cmpa_we (blk_hit && bus_addr[1:0] == SLOT_CMP_A),
      .cmpb_we (blk_hit && bus_addr[1:0] == SLOT_CMP_B),
      .wdata   (bus_wdata),
      .cnt_q   (cnt_a[c]),
      .rld_q   (rld_a[c]),
      .cmpa_q  (cmpa_a[c]),
      .cmpb_q  (cmpb_a[c]),
      .evt     (ev)
    );
    assign evt_all[EVT_PER_CH*c +: EVT_PER_CH] = ev;
  end

  tmr_irq #(.N_CH(N_CH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .evt_in  (evt_all),
    .clr_we  (bus_wr && bus_addr == STAT_IDX),
    .mask_we (bus_wr && bus_addr == MASK_IDX),
    .wbits   (bus_wdata[EV_W-1:0]),
    .irq_en  (ie),
    .st_q    (st_q),
    .mask_q  (mask_q),
    .irq_q   (tmr_irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (bus_addr[ADDR_W-1:2] == BLK_W'(c)) begin
        case (slot_e'(bus_addr[1:0]))
          SLOT_COUNT:  rd_mux = cnt_a[c];
          SLOT_RELOAD: rd_mux = rld_a[c];
          SLOT_CMP_A:  rd_mux = cmpa_a[c];
          default:     rd_mux = cmpb_a[c];
        endcase
      end
    end
    if (bus_addr == CTRL_IDX) rd_mux = CNT_W'(ctrl_q);
    if (bus_addr == STAT_IDX) rd_mux = CNT_W'(st_q);
    if (bus_addr == MASK_IDX) rd_mux = CNT_W'(mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/tb_tri_event_timer.sv
module tb_tri_event_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  tmr_irq;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  tri_event_timer dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tmr_irq(tmr_irq)
  );

  // reference state built from the requirements
  logic [31:0] m_cnt [3];
  logic [31:0] m_rld [3];
  logic [31:0] m_ca  [3];
  logic [31:0] m_cb  [3];
  logic [11:0] m_ctrl;
  logic [8:0]  m_st, m_mask;
  logic [2:0]  m_irq;
  logic [31:0] m_rd;

  function automatic logic [31:0] peek(input logic [3:0] a);
    if (a < 4'd12) begin
      case (a[1:0])
        2'd0: return m_cnt[a[3:2]];
        2'd1: return m_rld[a[3:2]];
        2'd2: return m_ca[a[3:2]];
        default: return m_cb[a[3:2]];
      endcase
    end
    if (a == 4'd12) return {20'd0, m_ctrl};
    if (a == 4'd13) return {23'd0, m_st};
    if (a == 4'd14) return {23'd0, m_mask};
    return 32'd0;
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] nc [3];
    logic [8:0]  ev;
    logic        en, up, cw;
    if (rst) begin
      for (int c = 0; c < 3; c++) begin
        m_cnt[c] = 0; m_rld[c] = 0; m_ca[c] = 0; m_cb[c] = 0;
      end
      m_ctrl = 0; m_st = 0; m_mask = 9'h1FF; m_irq = 0; m_rd = 0;
    end else begin
      if (bus_rd) m_rd = peek(bus_addr);
      for (int c = 0; c < 3; c++)
        m_irq[c] = m_ctrl[3*c+2] && (|(m_st[3*c +: 3] & ~m_mask[3*c +: 3]));
      ev = 0;
      for (int c = 0; c < 3; c++) begin
        en = m_ctrl[3*c];
        up = m_ctrl[9+c];
        cw = bus_wr && bus_addr == 4'(4*c);
        nc[c] = m_cnt[c];
        if (cw) nc[c] = bus_wdata;
        else if (en) begin
          if (m_cnt[c] == m_ca[c]) ev[3*c] = 1'b1;
          if (m_cnt[c] == m_cb[c]) ev[3*c+1] = 1'b1;
          if (up ? m_cnt[c] == 32'hFFFF_FFFF : m_cnt[c] == 0) begin
            ev[3*c+2] = 1'b1;
            nc[c] = m_rld[c];
          end else nc[c] = up ? m_cnt[c] + 1 : m_cnt[c] - 1;
        end
      end
      m_st = (m_st & ~((bus_wr && bus_addr == 4'd13) ? bus_wdata[8:0] : 9'd0)) | ev;
      for (int c = 0; c < 3; c++) begin
        m_cnt[c] = nc[c];
        if (bus_wr && bus_addr == 4'(4*c+1)) m_rld[c] = bus_wdata;
        if (bus_wr && bus_addr == 4'(4*c+2)) m_ca[c]  = bus_wdata;
        if (bus_wr && bus_addr == 4'(4*c+3)) m_cb[c]  = bus_wdata;
      end
      if (bus_wr && bus_addr == 4'd12) m_ctrl = bus_wdata[11:0];
      if (bus_wr && bus_addr == 4'd14) m_mask = bus_wdata[8:0];
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // interrupt lines compared with the model on every cycle
  always @(negedge clk)
    if (!rst && !ended) check("R9 irq", {29'd0, tmr_irq}, {29'd0, m_irq});

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp);
    check({tag, " model"}, bus_rdata, m_rd);
  endtask

  task automatic finish_run;
    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [31:0] pick_data();
    int k = $urandom_range(0, 3);
    if (k == 0) return 32'($urandom_range(0, 8));
    if (k == 1) return 32'hFFFF_FFF8 + 32'($urandom_range(0, 7));
    return $urandom;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=running exp=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R2: reset values over the whole map
    for (int a = 0; a < 16; a++)
      rd_chk(a == 14 ? "R1 mask" : "R1 R2 reset word", 4'(a), a == 14 ? 32'h1FF : 32'h0);
    check("R1 irq", {29'd0, tmr_irq}, 32'd0);

    // R3: counter write while running upward
    wr(4'd12, 32'h201);
    wr(4'd0, 32'd100);
    rd_chk("R3 count write", 4'd0, 32'd100);

    // R4: up wrap reloads instead of rolling to zero
    wr(4'd12, 32'h200);
    wr(4'd1, 32'd7);
    wr(4'd0, 32'hFFFF_FFFE);
    wr(4'd13, 32'h1FF);
    wr(4'd12, 32'h201);
    idle(2);
    wr(4'd12, 32'h200);
    rd_chk("R4 up wrap count", 4'd0, 32'd8);
    rd_chk("R4 wrap flag", 4'd13, 32'h004);

    // R5 / R7: down through zero with zero compares
    wr(4'd13, 32'h1FF);
    wr(4'd5, 32'd3);
    wr(4'd4, 32'd1);
    wr(4'd12, 32'h008);
    idle(2);
    wr(4'd12, 32'h000);
    rd_chk("R5 down wrap count", 4'd4, 32'd2);
    rd_chk("R5 R7 flags", 4'd13, 32'h038);

    // R6: frozen, then resumed for one clock
    idle(5);
    rd_chk("R6 frozen", 4'd4, 32'd2);
    wr(4'd12, 32'h008);
    wr(4'd12, 32'h000);
    rd_chk("R6 resumed", 4'd4, 32'd1);

    // R7: two compare values on channel 2 counting up
    wr(4'd13, 32'h1FF);
    wr(4'd10, 32'd50);
    wr(4'd11, 32'd52);
    wr(4'd8, 32'd48);
    wr(4'd12, 32'h840);
    idle(4);
    wr(4'd12, 32'h800);
    rd_chk("R7 compare flags", 4'd13, 32'h0C0);
    rd_chk("R7 count", 4'd8, 32'd53);

    // R8: write-one-to-clear, and event beating the clear
    wr(4'd13, 32'h040);
    rd_chk("R8 clear one bit", 4'd13, 32'h080);
    wr(4'd13, 32'h1FF);
    wr(4'd2, 32'd5);
    wr(4'd0, 32'd5);
    wr(4'd12, 32'h001);
    wr(4'd13, 32'h001);
    wr(4'd12, 32'h000);
    rd_chk("R8 event wins", 4'd13, 32'h001);

    // R9: mask, enable and one-clock lag
    wr(4'd14, 32'h1FE);
    idle(1);
    check("R9 no enable", {29'd0, tmr_irq}, 32'd0);
    wr(4'd12, 32'h004);
    check("R9 lag", {29'd0, tmr_irq}, 32'd0);
    idle(1);
    check("R9 raised", {29'd0, tmr_irq}, 32'd1);
    wr(4'd13, 32'h001);
    idle(1);
    check("R9 cleared", {29'd0, tmr_irq}, 32'd0);

    // R10: clock select alone does not run the counter
    wr(4'd0, 32'd33);
    wr(4'd12, 32'h002);
    idle(4);
    rd_chk("R10 select only", 4'd0, 32'd33);
    rd_chk("R10 readback", 4'd12, 32'h002);
    wr(4'd12, 32'h203);
    idle(2);
    wr(4'd12, 32'h000);
    rd_chk("R10 counts as usual", 4'd0, 32'd36);

    // random mix against the model
    for (int n = 0; n < 6000; n++) begin
      int op = $urandom_range(0, 9);
      logic [3:0] a = 4'($urandom_range(0, 15));
      bus_wr = 1'b0; bus_rd = 1'b0;
      if (op < 3) begin
        bus_wr = 1'b1; bus_addr = a; bus_wdata = pick_data();
        if (a == 4'd12) bus_wdata = $urandom & 32'hFFF;
        if (a == 4'd13 && $urandom_range(0, 3) != 0) bus_wr = 1'b0;
      end else if (op < 7) begin
        bus_rd = 1'b1; bus_addr = a;
      end
      @(negedge clk);
      if (bus_rd) check("R2 R3 R4 R5 R7 random read", bus_rdata, m_rd);
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
    idle(2);
    finish_run();
  end

endmodule